// File: doc/BRIEF.md
# Prioritized Physical Address Window Router

This block takes each 36-bit physical address issued by a processor core and names the on-chip target that owns it. The target might be the memory controller, the local bus controller or a PCI controller. Software programs a small set of general windows through a plain register write port. Each window has an enable, a base, a power-of-two size and a 4-bit target ID. Three fixed-purpose regions sit next to the general windows:

- an on-chip SRAM window, which is relocatable and resizable;
- a configuration-register window, 1 MB long, whose start address can be moved;
- a boot region, fixed at 0xFF800000 to 0xFFFFFFFF, which routes to whichever device the `boot_target` pin selects.

Regions may overlap, and a fixed priority settles which one wins. From highest to lowest, the order is the SRAM window, the configuration window, general windows in index order (window 0 first), and finally the boot region. An address that no region covers is reported as a miss.

Lookups flow in and out as valid/ready streams. A request is accepted on a clock edge where both `in_valid` and `in_ready` are high. The result appears in a single output register on the following cycle. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result stays frozen and `in_ready` drops, so back-pressure reaches the source without loss. A new request may be accepted in the same cycle that the previous result is consumed.

Top module: `law_router`

## Requirements
- R1: After reset all general windows and the SRAM window are disabled, the configuration base is 0xFF700000, `out_valid` is low and `in_ready` is high.
- R2: A general window with size code n covers 2^(n+1) bytes. Its base register holds address bits 35:12, and base bits below the size boundary are ignored when matching. Write data field positions are: enable in bit 34, size code in bits 33:28, target in bits 27:24, base in bits 23:0. Writes to addresses 0 to 7 program windows 0 to 7.
- R3: A size code below 11 (smaller than 4 KB) or above 34 (larger than 32 GB) disables its window, even when the enable bit is set.
- R4: When general windows overlap, the lower-numbered window supplies the target.
- R5: An address inside an enabled SRAM window returns target 0xC, whatever other regions match. Write address 9 programs the SRAM window with the same field layout as R2; its target field is unused.
- R6: The configuration window covers 1 MB from its base and returns target 0xF. It ranks above all general windows. Write address 8 loads its base bits 35:20 from write data bits 15:0.
- R7: Addresses 0xFF800000 to 0xFFFFFFFF that no higher region claims return the `boot_target` value with hit set.
- R8: An address matching no region gives miss high, hit low and target 0.
- R9: A result appears on the outputs the cycle after its request is accepted. Exactly one of hit and miss is high while `out_valid` is high.
- R10: While `out_valid` is high and `out_ready` is low, the result holds stable and `in_ready` is low. When `out_valid` is low, `in_ready` is high.
- R11: Writes to addresses 10 to 15 change no routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index (0-7 windows, 8 config base, 9 SRAM window) |
| cfg_wdata | input | 35 | Register write data |
| boot_target | input | 4 | Target ID of the selected boot device |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup request can be accepted |
| in_addr | input | 36 | Physical address to route |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_target | output | 4 | Target ID of the winning region |
| out_hit | output | 1 | Some region matched |
| out_miss | output | 1 | No region matched |

## Verification
The assertions check the following on every cycle:

- the handshake rules: results hold under stall, `in_ready` is high when idle, and a result follows each accept;
- that hit and miss are mutually exclusive;
- that a miss carries target zero;
- that any boot-range address always hits.

Only the bench's scenarios can show the routing decisions themselves. These are the window sizes and alignment masking, the disabling of out-of-range size codes, the overlap priority between windows, the SRAM and configuration override, configuration relocation, and ignored register writes. For this, the bench compares the outputs against a behavioural range-compare model on every clock.

// File: rtl/law_pkg.sv
package law_pkg;
  localparam int ADDR_W   = 36;
  localparam int PAGE_W   = 12;
  localparam int BASE_W   = ADDR_W - PAGE_W;
  localparam int SIZE_W   = 6;
  localparam int TGT_W    = 4;
  localparam int CFGR_W   = 20;               // 1 MB configuration region
  localparam int CBASE_W  = ADDR_W - CFGR_W;
  localparam int MIN_CODE = PAGE_W - 1;       // 4 KB
  localparam int MAX_CODE = 34;               // 32 GB
  localparam int WDATA_W  = 1 + SIZE_W + TGT_W + BASE_W;

  typedef struct packed {
    logic              en;
    logic [SIZE_W-1:0] size;
    logic [TGT_W-1:0]  tgt;
    logic [BASE_W-1:0] base;
  } win_t;

  function automatic logic win_match(input win_t w, input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] full_base;
    logic              usable;
    usable    = w.en && (w.size >= SIZE_W'(MIN_CODE)) && (w.size <= SIZE_W'(MAX_CODE));
    full_base = {w.base, {PAGE_W{1'b0}}};
    for (int i = 0; i < ADDR_W; i++)
      keep[i] = (i > int'(w.size));
    return usable && (((a ^ full_base) & keep) == '0);
  endfunction
endpackage

// File: rtl/law_cfg_regs.sv
module law_cfg_regs
  import law_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter int AW    = 4,
  parameter logic [CBASE_W-1:0] CFG_RST = 16'h0FF7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [WDATA_W-1:0] wdata,
  output win_t               win [N_WIN],
  output win_t               sram,
  output logic [CBASE_W-1:0] cfg_base
);
  localparam int CFG_IDX  = N_WIN;
  localparam int SRAM_IDX = N_WIN + 1;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)
        win[g] <= '0;
      else if (we && (int'(waddr) == g))
        win[g] <= win_t'(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram     <= '0;
      cfg_base <= CFG_RST;
    end else if (we) begin
      if (int'(waddr) == SRAM_IDX) sram     <= win_t'(wdata);
      if (int'(waddr) == CFG_IDX)  cfg_base <= wdata[CBASE_W-1:0];
    end
  end
endmodule

// File: rtl/law_match.sv
module law_match
  import law_pkg::*;
#(
  parameter int N_WIN = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  win_t               win [N_WIN],
  input  win_t               sram,
  input  logic [CBASE_W-1:0] cfg_base,
  output logic [N_WIN-1:0]   win_hit,
  output logic               sram_hit,
  output logic               cfg_hit,
  output logic               boot_hit
);
  localparam logic [ADDR_W-24:0] BOOT_TAG = 13'h1FF;  // 0xFF800000 >> 23

  for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
    assign win_hit[g] = win_match(win[g], addr);
  end

  assign sram_hit = win_match(sram, addr);
  assign cfg_hit  = (addr[ADDR_W-1:CFGR_W] == cfg_base);
  assign boot_hit = (addr[ADDR_W-1:23] == BOOT_TAG);
endmodule

// File: rtl/law_select.sv
module law_select
  import law_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter logic [TGT_W-1:0] SRAM_TGT = 4'hC,
  parameter logic [TGT_W-1:0] CFG_TGT  = 4'hF
) (
  input  logic [N_WIN-1:0] win_hit,
  input  win_t             win [N_WIN],
  input  logic             sram_hit,
  input  logic             cfg_hit,
  input  logic             boot_hit,
  input  logic [TGT_W-1:0] boot_target,
  output logic [TGT_W-1:0] tgt,
  output logic             hit
);
  logic [TGT_W-1:0] win_tgt;
  logic             any_win;

  always_comb begin
    win_tgt = '0;
    any_win = |win_hit;
    for (int i = N_WIN - 1; i >= 0; i--)
      if (win_hit[i]) win_tgt = win[i].tgt;
  end

  always_comb begin
    hit = 1'b1;
    if (sram_hit)      tgt = SRAM_TGT;
    else if (cfg_hit)  tgt = CFG_TGT;
    else if (any_win)  tgt = win_tgt;
    else if (boot_hit) tgt = boot_target;
    else begin
      tgt = '0;
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/law_router.sv
module law_router
  import law_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter logic [TGT_W-1:0] SRAM_TGT = 4'hC,
  parameter logic [TGT_W-1:0] CFG_TGT  = 4'hF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(N_WIN+2)-1:0]   cfg_addr,
  input  logic [law_pkg::WDATA_W-1:0]  cfg_wdata,
  input  logic [law_pkg::TGT_W-1:0]    boot_target,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [law_pkg::ADDR_W-1:0]   in_addr,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [law_pkg::TGT_W-1:0]    out_target,
  output logic                         out_hit,
  output logic                         out_miss
);
  localparam int AW = $clog2(N_WIN + 2);

  win_t               win [N_WIN];
  win_t               sram;
  logic [CBASE_W-1:0] cfg_base;
  logic [N_WIN-1:0]   win_hit;
  logic               sram_hit, cfg_hit, boot_hit;
  logic [TGT_W-1:0]   sel_tgt;
  logic               sel_hit;
  logic               accept;

  law_cfg_regs #(.N_WIN(N_WIN), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .win(win), .sram(sram), .cfg_base(cfg_base)
  );

  law_match #(.N_WIN(N_WIN)) u_match (
    .addr(in_addr), .win(win), .sram(sram), .cfg_base(cfg_base),
    .win_hit(win_hit), .sram_hit(sram_hit), .cfg_hit(cfg_hit), .boot_hit(boot_hit)
  );

  law_select #(.N_WIN(N_WIN), .SRAM_TGT(SRAM_TGT), .CFG_TGT(CFG_TGT)) u_sel (
    .win_hit(win_hit), .win(win), .sram_hit(sram_hit), .cfg_hit(cfg_hit),
    .boot_hit(boot_hit), .boot_target(boot_target), .tgt(sel_tgt), .hit(sel_hit)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_target <= '0;
      out_hit    <= 1'b0;
      out_miss   <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_target <= sel_tgt;
      out_hit    <= sel_hit;
      out_miss   <= !sel_hit;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/law_router_chk.sv
module law_router_chk #(
  parameter int N_WIN = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [35:0]                in_addr,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [3:0]                 out_target,
  input logic                       out_hit,
  input logic                       out_miss
);
  // R9
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit ^ out_miss));

  // R8
  miss_zero_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_target == 4'h0));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target)
                                   && $stable(out_hit) && $stable(out_miss)));

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  boot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_addr[35:23] == 13'h1FF) |=> out_hit);
endmodule

bind law_router law_router_chk #(.N_WIN(N_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_target(out_target), .out_hit(out_hit), .out_miss(out_miss)
);

// File: tb/law_router_tb.sv
module law_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [34:0] cfg_wdata = '0;
  logic [3:0]  boot_target = 4'h7;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_target;
  logic        out_hit, out_miss;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;  // 200 MHz

  law_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .boot_target(boot_target), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_target(out_target), .out_hit(out_hit),
    .out_miss(out_miss)
  );

  // ---------------- behavioural reference model ----------------
  logic        m_en [10];
  int          m_size [10];
  logic [3:0]  m_tgt [10];
  logic [23:0] m_base [10];
  logic [15:0] m_cfg;
  logic        e_valid;
  logic [3:0]  e_tgt;
  logic        e_hit;

  function automatic logic in_win(int k, longint unsigned a);
    longint unsigned sz, b;
    if (!m_en[k] || m_size[k] < 11 || m_size[k] > 34) return 1'b0;
    sz = 64'd1 << (m_size[k] + 1);
    b  = longint'(m_base[k]) * 4096;
    b  = (b / sz) * sz;
    return (a >= b) && (a < b + sz);
  endfunction

  task automatic ref_decode(input logic [35:0] addr, output logic [3:0] t, output logic h);
    longint unsigned a = longint'(addr);
    longint unsigned cb = longint'(m_cfg) * 1048576;
    h = 1'b1;
    if (in_win(9, a)) begin t = 4'hC; return; end
    if (a >= cb && a < cb + 1048576) begin t = 4'hF; return; end
    for (int k = 0; k < 8; k++)
      if (in_win(k, a)) begin t = m_tgt[k]; return; end
    if (a >= 64'hFF80_0000 && a <= 64'hFFFF_FFFF) begin t = boot_target; return; end
    t = 4'h0;
    h = 1'b0;
  endtask

  always @(posedge clk) begin
    logic [3:0] t;
    logic       h;
    if (!rst_n) begin
      for (int k = 0; k < 10; k++) begin
        m_en[k] = 0; m_size[k] = 0; m_tgt[k] = 0; m_base[k] = 0;
      end
      m_cfg = 16'h0FF7;
      e_valid = 0; e_tgt = 0; e_hit = 0;
    end else begin
      if (in_valid && (!e_valid || out_ready)) begin
        ref_decode(in_addr, t, h);
        e_valid = 1; e_tgt = t; e_hit = h;
      end else if (out_ready) begin
        e_valid = 0;
      end
      if (cfg_we) begin
        if (cfg_addr < 8 || cfg_addr == 9) begin
          m_en[cfg_addr]   = cfg_wdata[34];
          m_size[cfg_addr] = int'(cfg_wdata[33:28]);
          m_tgt[cfg_addr]  = cfg_wdata[27:24];
          m_base[cfg_addr] = cfg_wdata[23:0];
        end else if (cfg_addr == 8) begin
          m_cfg = cfg_wdata[15:0];
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic ok;
      ok = (in_ready == (!e_valid || out_ready)) && (out_valid == e_valid);
      if (e_valid)
        ok = ok && (out_target == e_tgt) && (out_hit == e_hit) && (out_miss == !e_hit);
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s: got rdy=%0b v=%0b tgt=%h hit=%0b miss=%0b exp rdy=%0b v=%0b tgt=%h hit=%0b",
                 cur_req, in_ready, out_valid, out_target, out_hit, out_miss,
                 (!e_valid || out_ready), e_valid, e_tgt, e_hit);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [34:0] wword(logic en, int size, logic [3:0] tgt, logic [35:0] base);
    return {en, 6'(size), tgt, base[35:12]};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [34:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(input logic [35:0] a);
    in_valid = 1; in_addr = a;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: got v=%0b rdy=%0b exp v=0 rdy=1", out_valid, in_ready);
    end
    cur_req = "R1"; look(36'h0_FF70_0010); look(36'h1_0000_0000);
    cur_req = "R8"; look(36'h0_0000_0000); look(36'h8_1234_5000);

    cur_req = "R2";
    wr(4'd0, wword(1, 11, 4'h1, 36'h0_0000_0000));
    look(36'h0_0000_0FFF); look(36'h0_0000_1000);
    wr(4'd1, wword(1, 29, 4'h2, 36'h0_4012_3000));
    look(36'h0_4000_0000); look(36'h0_7FFF_FFFF); look(36'h0_8000_0000);

    cur_req = "R3";
    wr(4'd5, wword(1, 10, 4'h5, 36'h2_0000_0000)); look(36'h2_0000_0000);
    wr(4'd6, wword(1, 35, 4'h6, 36'h0)); look(36'h3_0000_0000);
    wr(4'd6, wword(0, 20, 4'h6, 36'h3_0000_0000)); look(36'h3_0000_0000);

    cur_req = "R4";
    wr(4'd3, wword(1, 34, 4'h3, 36'h0));
    look(36'h0_0000_0010); look(36'h0_4000_0010); look(36'h9_0000_0000);
    look(36'h0_FFFF_FFFC);
    wr(4'd2, wword(1, 15, 4'h8, 36'h0_0000_0000)); look(36'h0_0000_0010);
    wr(4'd3, wword(0, 34, 4'h3, 36'h0));

    cur_req = "R7";
    look(36'h0_FFFF_FFFC); look(36'h0_FF80_0000);
    boot_target = 4'h9; look(36'h0_FFC0_0000);
    look(36'h0_FF7F_FFFF); look(36'h1_FF80_0000);

    cur_req = "R6";
    wr(4'd8, 35'h0_0400);
    look(36'h0_4000_0010); look(36'h0_4010_0000); look(36'h0_FF70_0000);

    cur_req = "R5";
    wr(4'd9, wword(1, 17, 4'h0, 36'h0_4000_0000));
    look(36'h0_4000_0010); look(36'h0_4004_0000);
    wr(4'd9, wword(1, 11, 4'h0, 36'h0_FFFF_F000)); look(36'h0_FFFF_FFFC);

    cur_req = "R11";
    wr(4'd12, 35'h7_FFFF_FFFF); wr(4'd10, 35'h0);
    look(36'h0_4000_0010); look(36'h0_FFFF_FFFC); look(36'h9_0000_0000);

    cur_req = "R10";
    out_ready = 0;
    look(36'h0_0000_0010);
    repeat (2) @(negedge clk);
    fork
      look(36'h0_8000_0000);
      begin repeat (3) @(negedge clk); out_ready = 1; end
    join
    repeat (2) @(negedge clk);

    cur_req = "R9";
    in_valid = 1;
    for (int k = 0; k < 6; k++) begin
      in_addr = 36'h0_4000_0000 + 36'(k) * 36'h0004_0000;
      @(negedge clk);
    end
    in_valid = 0;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule